// File: doc/BRIEF.md
# Frame-Synchronous Word Scrambler

This block whitens a framed 48-bit-per-clock stream. Each data word is XORed with 48 bits of a pseudo-random keystream drawn from a 16-bit linear feedback shift register. The register is restarted on every frame, so the transmitter and the receiver stay in step without any side channel. The first word of a frame carries the 6-byte alignment word, and that word is never scrambled. In transmit mode the output mux replaces that word with the fixed pattern F6F6F6282828, regardless of what arrived on the input.

XOR with the same keystream is its own inverse, so the receive side uses the same block with the alignment insertion switched off. In that mode the alignment beat passes straight through and every other beat is descrambled. Idle cycles (input not valid) leave the keystream where it was and drive an all-ones idle pattern on the output.

Top module: `frame_scrambler`

## Requirements
- R1: Reset state. While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is all ones. The shift register starts at 16'hFFFF, so valid words that arrive before the first start-of-frame are scrambled with the keystream seeded from all ones.
- R2: Latency is one clock. A beat presented with `in_valid`=1 at a rising edge appears at that edge, and `out_valid` is 1 in the following cycle exactly when the input beat was valid.
- R3: On a valid beat with `in_sof`=0, `out_data` = `in_data` XOR K. K is the next 48 keystream bits, and the earliest bit is placed at bit 47 (transmission order is MSB first).
- R4: Keystream rule for state s[15:0] (polynomial x^16+x^12+x^3+x+1):
  - Each keystream bit is s[15].
  - After each bit the state becomes {s[14:0], s[15]^s[11]^s[2]^s[0]}.
  - A scrambled beat consumes exactly 48 steps.
- R5: On a valid beat with `in_sof`=1 and `insert_aw`=1, `out_data` is 48'hF6F6F6282828, with byte F6 in bits 47:40. The input word is ignored.
- R6: On a valid beat with `in_sof`=1 and `insert_aw`=0, `out_data` equals `in_data` unscrambled.
- R7: Every valid start-of-frame beat reloads the register with 16'hFFFF. The next valid word, which is byte 7 of the frame onward, is therefore scrambled with the keystream from the all-ones seed. Back-to-back start-of-frame beats each reseed.
- R8: On a beat with `in_valid`=0, the next cycle shows `out_valid`=0 and `out_data` all ones. In that case `in_sof` is ignored and the register is left unchanged, so the next valid word continues the keystream.
- R9: Two instances in series, the second with `insert_aw`=0 and fed the first one's start-of-frame delayed one cycle, return every non-alignment data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_sof | input | 1 | Input word is the alignment beat (start of frame) |
| insert_aw | input | 1 | 1: replace the alignment beat with the fixed pattern; 0: pass it through |
| in_data | input | 48 | Input word, bit 47 earliest on the line |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 48 | Scrambled/descrambled word, all ones when idle |

## Verification
On a start-of-frame beat the block does two things in the same clock: it emits or passes the alignment word, and it reseeds the keystream. Both can also coincide with the tail of the previous frame's scrambling. The bench provokes this with consecutive start-of-frame beats and with a start-of-frame beat that follows scrambled data directly. It then judges the following word against a keystream computed bit by bit from the all-ones seed. A start-of-frame pulse held during an invalid cycle is also driven. The next valid word must then continue the old keystream, which shows that no reseed happened.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int          DATA_W     = 48;
  localparam int          LFSR_W     = 16;
  // feedback taps besides the top bit: s[11], s[2], s[0]
  localparam logic [15:0] TAP_MASK   = 16'h0805;
  localparam logic [15:0] SEED       = 16'hFFFF;
  localparam logic [47:0] ALIGN_WORD = 48'hF6F6F6282828;
endpackage

// File: rtl/scr_keygen.sv
module scr_keygen #(
  parameter int              SW   = 16,
  parameter int              DW   = 48,
  parameter logic [SW-1:0]   TAPS = 16'h0805,
  parameter logic [SW-1:0]   SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          reseed,
  output logic [DW-1:0] ks
);
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_jump;

  // one serial step of the register
  function automatic logic [SW-1:0] lfsr_adv(input logic [SW-1:0] s);
    return {s[SW-2:0], s[SW-1] ^ (^(s & TAPS))};
  endfunction

  // DW keystream bits, earliest in the MSB
  function automatic logic [DW-1:0] ks_word(input logic [SW-1:0] s);
    logic [SW-1:0] st;
    logic [DW-1:0] w;
    st = s;
    for (int i = 0; i < DW; i++) begin
      w[DW-1-i] = st[SW-1];
      st = lfsr_adv(st);
    end
    return w;
  endfunction

  function automatic logic [SW-1:0] state_after(input logic [SW-1:0] s);
    logic [SW-1:0] st;
    st = s;
    for (int i = 0; i < DW; i++) st = lfsr_adv(st);
    return st;
  endfunction

  assign ks         = ks_word(state_q);
  assign state_jump = state_after(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SEED;
    else if (reseed) state_q <= SEED;
    else if (step)   state_q <= state_jump;
  end

  // R7: a start-of-frame beat leaves the seed in the register
  p_reseed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (state_q == SEED));
  // R8: no valid beat, no movement
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reseed) |=> $stable(state_q));
  // R1: seeded out of reset
  p_seed_r1: assert property (@(posedge clk)
    !rst_n |=> (state_q == SEED) || !rst_n);
endmodule

// File: rtl/scr_mixer.sv
module scr_mixer #(
  parameter int            DW    = 48,
  parameter logic [DW-1:0] ALIGN = 48'hF6F6F6282828
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          insert_aw,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] ks,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] whitened;
  logic [DW-1:0] sof_word;
  logic [DW-1:0] next_word;

  assign whitened  = in_data ^ ks;
  assign sof_word  = insert_aw ? ALIGN : in_data;

  always_comb begin
    if (!in_valid)   next_word = '1;
    else if (in_sof) next_word = sof_word;
    else             next_word = whitened;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '1;
    end else begin
      out_valid <= in_valid;
      out_data  <= next_word;
    end
  end

  // R2: one cycle from input to output
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8: idle pattern
  p_idle_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && (out_data == '1)));
  // R5: alignment insertion
  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && insert_aw) |=> (out_data == ALIGN));
  // R6: pass-through of the alignment beat
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !insert_aw) |=> (out_data == $past(in_data)));
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
  import scr_pkg::*;
#(
  parameter int                DW    = DATA_W,
  parameter int                SW    = LFSR_W,
  parameter logic [LFSR_W-1:0] TAPS  = TAP_MASK,
  parameter logic [LFSR_W-1:0] SEEDV = SEED,
  parameter logic [DATA_W-1:0] ALIGN = ALIGN_WORD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          insert_aw,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  // named events for the checks
  logic          ev_scramble;
  logic          ev_reseed;
  logic [DW-1:0] ks;

  assign ev_scramble = in_valid && !in_sof;
  assign ev_reseed   = in_valid && in_sof;

  scr_keygen #(.SW(SW), .DW(DW), .TAPS(TAPS), .SEED(SEEDV)) u_keygen (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (ev_scramble),
    .reseed (ev_reseed),
    .ks     (ks)
  );

  scr_mixer #(.DW(DW), .ALIGN(ALIGN)) u_mixer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .insert_aw (insert_aw),
    .in_data   (in_data),
    .ks        (ks),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R3: a scrambled beat never shows the plain word when the keystream is nonzero
  p_scramble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_scramble && (ks != '0)) |=> (out_data != $past(in_data)));
endmodule

// File: tb/tb_frame_scrambler.sv
module tb_frame_scrambler;
  localparam logic [47:0] AW = 48'hF6F6F6282828;

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_sof, insert_aw, rx_sof;
  logic [47:0] in_data;
  logic        out_valid, rx_valid;
  logic [47:0] out_data, rx_data;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_st;
  logic        p1_v, p1_sof;
  logic [47:0] p1_d, p1_exp;
  logic        first_flag, after_sof, after_gap;

  frame_scrambler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .insert_aw(insert_aw), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  frame_scrambler dut_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(out_valid), .in_sof(rx_sof),
    .insert_aw(1'b0), .in_data(out_data),
    .out_valid(rx_valid), .out_data(rx_data));

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial keystream per R4
  task automatic gen(output logic [47:0] k);
    for (int b = 47; b >= 0; b--) begin
      k[b] = m_st[15];
      m_st = {m_st[14:0], m_st[15] ^ m_st[11] ^ m_st[2] ^ m_st[0]};
    end
  endtask

  task automatic beat(input logic v, input logic sof, input logic aw, input logic [47:0] d);
    logic [47:0] exp, k;
    string tag;
    @(negedge clk);
    in_valid = v; in_sof = sof; insert_aw = aw; in_data = d; rx_sof = p1_sof;
    if (!v)            tag = "R8";
    else if (sof)      tag = aw ? "R5" : "R6";
    else if (first_flag) tag = "R1";
    else if (after_sof)  tag = "R7";
    else if (after_gap)  tag = "R8";
    else if (d == '0)    tag = "R4";
    else                 tag = "R3";
    if (!v) exp = '1;
    else if (sof) begin exp = aw ? AW : d; m_st = 16'hFFFF; end
    else begin gen(k); exp = d ^ k; end
    @(posedge clk); #1;
    chk("R2", {47'd0, out_valid}, {47'd0, v});
    chk(tag, out_data, exp);
    if (p1_v) begin
      chk("R9", {47'd0, rx_valid}, 48'd1);
      chk("R9", rx_data, p1_sof ? p1_exp : p1_d);
    end else begin
      chk("R8", {47'd0, rx_valid}, 48'd0);
    end
    p1_v = v; p1_sof = sof; p1_d = d; p1_exp = exp;
    if (v) begin
      first_flag = 1'b0;
      after_gap  = 1'b0;
      after_sof  = sof;
    end else begin
      after_gap  = 1'b1;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_sof = 0; insert_aw = 1; in_data = '0; rx_sof = 0;
    m_st = 16'hFFFF; p1_v = 0; p1_sof = 0; p1_d = '0; p1_exp = '0;
    first_flag = 1; after_sof = 0; after_gap = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {47'd0, out_valid}, 48'd0);
    chk("R1", out_data, '1);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", {47'd0, out_valid}, 48'd0);
    chk("R1", out_data, '1);
    // before any frame: seed keystream
    for (int i = 0; i < 3; i++) beat(1, 0, 1, 48'd0);
    // long zero frame exposes keystream (R4)
    beat(1, 1, 1, 48'h123456789ABC);
    for (int i = 0; i < 600; i++) beat(1, 0, 1, 48'd0);
    // gap with a stray start-of-frame while invalid (R8)
    beat(0, 1, 1, 48'hDEADBEEF0000);
    beat(0, 0, 1, 48'd0);
    for (int i = 0; i < 20; i++) beat(1, 0, 1, 48'd0);
    // random frame with periodic idle beats
    beat(1, 1, 1, 48'd0);
    for (int i = 0; i < 300; i++) begin
      if (i % 7 == 3) beat(0, i % 2 == 0, 1, 48'hFFFF00000000);
      else            beat(1, 0, 1, 48'({$urandom(), $urandom()}));
    end
    // back-to-back and adjacent starts of frame (R7)
    beat(1, 1, 1, 48'hAAAAAAAAAAAA);
    beat(1, 1, 1, 48'h555555555555);
    beat(1, 0, 1, 48'd0);
    beat(1, 1, 1, 48'd1);
    beat(1, 0, 1, 48'hFFFFFFFFFFFF);
    beat(1, 0, 1, 48'd0);
    // pass-through mode on the alignment beat (R6)
    beat(1, 1, 0, 48'h0123456789AB);
    for (int i = 0; i < 100; i++) beat(1, 0, 0, 48'(i) * 48'h000100010001);
    beat(1, 1, 0, AW);
    for (int i = 0; i < 100; i++) beat(1, 0, 1, '1);
    // flush the receive copy
    beat(0, 0, 1, 48'd0);
    beat(0, 0, 1, 48'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule